// File: doc/BRIEF.md
# Device-Register Window Base Decoder

This block keeps the base register of a memory-mapped window that holds device registers, and sorts physical request addresses between that window and ordinary memory. Software sees one 32-bit register: the upper field places the window in a 36-bit physical space, one bit switches the window on, and two preset fields report how many 64-byte blocks the window spans and whether its first block holds window-control registers.

The address side is purely combinational. A 36-bit request address is compared against the window in the same cycle. The block raises a hit for the device-register logic, gives the 64-byte block number inside the window, and flags an access to the reserved control block. An access-permission input gates the register port: while it is low, reads return zero and writes have no effect. Address decoding keeps running while the gate is low.

Top module: `devwin_decoder`

## Requirements
- R1: After synchronous reset the enable bit (bit 10) and the whole base field (bits 31..11) read as 0; bits 9..0 show the presets.
- R2: A read with permission returns base in bits 31..11 (physical address bits 35..15), the enable in bit 10, the reserved-block flag in bit 9 and the block count N in bits 8..0.
- R3: Bits 9..0 are read-only presets; writes to them have no effect on what is read back.
- R4: With an implemented physical width of PA bits (32..36), register bits 31 down to PA-4 ignore writes and read as 0.
- R5: While the permission input is low, reads return 0x00000000 and writes leave the register unchanged.
- R6: While the enable bit is 0, no request address produces a hit, a non-zero block index or a control-block flag.
- R7: With the enable bit set, a request hits in the same cycle exactly when base <= address < base + (N+1)*64, where base is the base field shifted left by 15.
- R8: On a hit the block index equals (address - base) / 64; without a hit it is 0.
- R9: The control-block flag is 1 exactly when there is a hit, the block index is 0 and the reserved-block preset is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_allow | input | 1 | Register access permission |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| req_addr | input | 36 | Physical request address |
| dev_hit | output | 1 | Request goes to the device-register logic |
| blk_idx | output | 9 | 64-byte block number within the window |
| ctl_blk | output | 1 | Request targets the reserved control block |

## Verification
The assertions assume the preset count and reserved flag stay constant and that the write strobe is a clean level sampled at the clock. They also assume that request addresses may take any 36-bit value, including values with bits above the implemented width set. The stimulus holds every input steady across each clock edge. It sweeps addresses just below the base, at the base, across each block boundary, at the last byte and one past it, and above the implemented width. It also writes all-ones and patterned words both with and without permission, so that the masked bits and the gate are exercised on the very values the assertions cover.

// File: rtl/dwin_pkg.sv
package dwin_pkg;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 36;
  localparam int BLK_SHIFT  = 6;
  localparam int CNT_W      = 9;
  localparam int BASE_LSB   = 11;
  localparam int BASE_W     = REG_W - BASE_LSB;
  localparam int ADDR_GRAN  = ADDR_W - BASE_W;
  localparam int EN_BIT     = 10;
  localparam int RSV_BIT    = 9;
  localparam int SPAN_W     = CNT_W + BLK_SHIFT + 1;
endpackage

// File: rtl/dwin_basereg.sv
module dwin_basereg
  import dwin_pkg::*;
#(
  parameter int               PA_WIDTH   = 36,
  parameter logic [CNT_W-1:0] CNT_PRESET = 9'd7,
  parameter logic             RSV_PRESET = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_allow,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  output logic [BASE_W-1:0] base_field,
  output logic              enable,
  output logic [REG_W-1:0]  rdata
);
  localparam int IMPL_BITS = PA_WIDTH - ADDR_GRAN;

  logic [BASE_W-1:0] keep_mask;
  logic [BASE_W-1:0] base_q;
  logic              en_q;
  logic              wr_ok;

  genvar gi;
  generate
    for (gi = 0; gi < BASE_W; gi++) begin : g_mask
      if (gi < IMPL_BITS) begin : g_impl
        assign keep_mask[gi] = 1'b1;
      end else begin : g_unimpl
        assign keep_mask[gi] = 1'b0;
      end
    end
  endgenerate

  assign wr_ok = wr & acc_allow;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_ok) begin
      base_q <= wdata[REG_W-1:BASE_LSB] & keep_mask;
      en_q   <= wdata[EN_BIT];
    end
  end

  assign base_field = base_q;
  assign enable     = en_q;

  always_comb begin
    if (acc_allow) rdata = {base_q, en_q, RSV_PRESET, CNT_PRESET};
    else           rdata = '0;
  end

  AST_GATED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!acc_allow) |=> ($stable(base_q) && $stable(en_q))) else $error("gated write changed state"); // R5

  AST_RSV_READBACK: assert property (@(posedge clk) disable iff (rst)
    acc_allow |-> (rdata[RSV_BIT] == RSV_PRESET)) else $error("preset flag altered"); // R3

  generate
    if (IMPL_BITS < BASE_W) begin : g_unimpl_chk
      AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
        base_q[BASE_W-1:IMPL_BITS] == '0) else $error("unimplemented base bit set"); // R4
    end
  endgenerate
endmodule

// File: rtl/dwin_span.sv
module dwin_span
  import dwin_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic [CW-1:0]         count,
  output logic [CW+BLK_SHIFT:0] span_bytes
);
  logic [CW:0] nblocks;
  assign nblocks    = {1'b0, count} + 1'b1;
  assign span_bytes = {nblocks, {BLK_SHIFT{1'b0}}};
endmodule

// File: rtl/dwin_match.sv
module dwin_match
  import dwin_pkg::*;
#(
  parameter logic RSV_PRESET = 1'b1
) (
  input  logic [BASE_W-1:0] base_field,
  input  logic              enable,
  input  logic [SPAN_W-1:0] span_bytes,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hit,
  output logic [CNT_W-1:0]  idx,
  output logic              ctl
);
  logic [ADDR_W-1:0] base_addr;
  logic [ADDR_W-1:0] offset;
  logic              above;
  logic              below;

  assign base_addr = {base_field, {ADDR_GRAN{1'b0}}};
  assign offset    = req_addr - base_addr;
  assign above     = (req_addr >= base_addr);
  assign below     = (offset < {{(ADDR_W-SPAN_W){1'b0}}, span_bytes});
  assign hit       = enable & above & below;

  always_comb begin
    if (hit) idx = offset[BLK_SHIFT +: CNT_W];
    else     idx = '0;
  end

  assign ctl = hit & RSV_PRESET & (idx == '0);
endmodule

// File: rtl/devwin_decoder.sv
module devwin_decoder
  import dwin_pkg::*;
#(
  parameter int               PA_WIDTH   = 36,
  parameter logic [CNT_W-1:0] CNT_PRESET = 9'd7,
  parameter logic             RSV_PRESET = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_allow,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              dev_hit,
  output logic [CNT_W-1:0]  blk_idx,
  output logic              ctl_blk
);
  logic [BASE_W-1:0] base_field;
  logic              enable;
  logic [SPAN_W-1:0] span_bytes;

  dwin_basereg #(
    .PA_WIDTH  (PA_WIDTH),
    .CNT_PRESET(CNT_PRESET),
    .RSV_PRESET(RSV_PRESET)
  ) u_reg (
    .clk       (clk),
    .rst       (rst),
    .acc_allow (acc_allow),
    .wr        (reg_wr),
    .wdata     (reg_wdata),
    .base_field(base_field),
    .enable    (enable),
    .rdata     (reg_rdata)
  );

  dwin_span #(.CW(CNT_W)) u_span (
    .count     (CNT_PRESET),
    .span_bytes(span_bytes)
  );

  dwin_match #(.RSV_PRESET(RSV_PRESET)) u_match (
    .base_field(base_field),
    .enable    (enable),
    .span_bytes(span_bytes),
    .req_addr  (req_addr),
    .hit       (dev_hit),
    .idx       (blk_idx),
    .ctl       (ctl_blk)
  );

  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (!enable) |-> (!dev_hit && blk_idx == '0 && !ctl_blk)) else $error("hit while disabled"); // R6

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    dev_hit |-> (blk_idx <= CNT_PRESET)) else $error("index past window"); // R8

  AST_HIT_BASE_MATCH: assert property (@(posedge clk) disable iff (rst)
    dev_hit |-> (req_addr[ADDR_W-1:ADDR_GRAN] == base_field)) else $error("hit outside base"); // R7

  AST_CTL_FIRST_BLOCK: assert property (@(posedge clk) disable iff (rst)
    ctl_blk |-> (dev_hit && blk_idx == '0)) else $error("control flag off block 0"); // R9

  AST_GATE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!acc_allow) |-> (reg_rdata == '0)) else $error("gated read nonzero"); // R5
endmodule

// File: tb/devwin_decoder_test.sv
module devwin_decoder_test;
  localparam int         PA   = 34;
  localparam logic [8:0] CNT  = 9'd5;
  localparam logic       RSV  = 1'b1;

  logic        clk = 1'b0;
  logic        rst;
  logic        acc_allow;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [35:0] req_addr;
  logic        dev_hit;
  logic [8:0]  blk_idx;
  logic        ctl_blk;

  int checks = 0;
  int errors = 0;

  longint m_base;   // base field value (21 bits)
  bit     m_en;

  always #10 clk = ~clk;

  devwin_decoder #(.PA_WIDTH(PA), .CNT_PRESET(CNT), .RSV_PRESET(RSV)) uut (
    .clk(clk), .rst(rst), .acc_allow(acc_allow), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_addr(req_addr),
    .dev_hit(dev_hit), .blk_idx(blk_idx), .ctl_blk(ctl_blk)
  );

  task automatic check32(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    longint base_a, lim, a, e_rd;
    bit e_hit;
    longint e_idx;
    bit e_ctl;
    base_a = m_base * 64'd32768;
    lim    = base_a + (longint'(CNT) + 1) * 64;
    a      = longint'(req_addr);
    e_hit  = m_en && (a >= base_a) && (a < lim);
    e_idx  = e_hit ? (a - base_a) / 64 : 0;
    e_ctl  = e_hit && (e_idx == 0) && RSV;
    e_rd   = acc_allow ? ((m_base * 2048) + (longint'(m_en) * 1024) + (longint'(RSV) * 512) + longint'(CNT)) : 0;
    check32("R2 R3 R4 R5 rdata", longint'(reg_rdata), e_rd);
    check32("R6 R7 dev_hit", longint'(dev_hit), longint'(e_hit));
    check32("R8 blk_idx", longint'(blk_idx), e_idx);
    check32("R9 ctl_blk", longint'(ctl_blk), longint'(e_ctl));
  endtask

  task automatic cyc(bit wr, logic [31:0] wd, bit allow, logic [35:0] addr);
    longint nb;
    reg_wr = wr; reg_wdata = wd; acc_allow = allow; req_addr = addr;
    #8;
    compare_all();
    @(posedge clk);
    if (rst) begin
      m_base = 0; m_en = 0;
    end else if (wr && allow) begin
      nb = 0;
      for (int i = 11; i < 32; i++)
        if (wd[i] && (i + 4 < PA)) nb = nb + (longint'(1) << (i - 11));
      m_base = nb;
      m_en   = wd[10];
    end
    #1;
  endtask

  function automatic logic [31:0] mkreg(longint b, bit en, logic [9:0] low);
    return (32'(b) << 11) | (32'(en) << 10) | 32'(low);
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint b;
    longint base_a;
    m_base = 0; m_en = 0;
    rst = 1'b1; reg_wr = 0; reg_wdata = 0; acc_allow = 1; req_addr = 0;
    @(posedge clk); #1;
    cyc(0, 0, 1, 36'h0);
    rst = 1'b0;
    // R1: reset state
    #8;
    check32("R1 reset rdata", longint'(reg_rdata), (longint'(RSV) * 512) + longint'(CNT));
    check32("R1 reset hit", longint'(dev_hit), 0);
    @(posedge clk); #1;
    cyc(0, 0, 1, 36'h0);                    // R6: disabled, address 0
    // R5: gated write ignored, gated read zero
    cyc(1, 32'hFFFF_FFFF, 0, 36'h0);
    cyc(0, 0, 1, 36'h0);
    // R4 R3: all-ones write keeps only implemented bits, presets unchanged
    cyc(1, 32'hFFFF_FFFF, 1, 36'h0);
    cyc(0, 0, 1, 36'h3_FFFF_8000);
    cyc(0, 0, 0, 36'h3_FFFF_8000);
    // R7 R8 R9: patterned base, enabled
    b = 64'h0ABCD;
    base_a = b * 32768;
    cyc(1, mkreg(b, 1, 10'h155), 1, 36'h0);
    cyc(0, 0, 1, 36'(base_a - 1));
    cyc(0, 0, 1, 36'(base_a));
    cyc(0, 0, 1, 36'(base_a + 63));
    cyc(0, 0, 1, 36'(base_a + 64));
    cyc(0, 0, 1, 36'(base_a + 200));
    cyc(0, 0, 1, 36'(base_a + 383));
    cyc(0, 0, 1, 36'(base_a + 384));
    cyc(0, 0, 1, 36'(base_a + 32767));
    cyc(0, 0, 1, 36'(base_a) | 36'h4_0000_0000);   // above implemented width
    cyc(0, 0, 0, 36'(base_a + 128));               // gate does not stop decode
    // R5: gated write attempt to disable; still hits
    cyc(1, 32'h0, 0, 36'(base_a + 64));
    cyc(0, 0, 1, 36'(base_a + 64));
    // R6: disable, same addresses miss
    cyc(1, mkreg(b, 0, 10'h000), 1, 36'(base_a));
    cyc(0, 0, 1, 36'(base_a));
    cyc(0, 0, 1, 36'(base_a + 320));
    // base zero region at bottom of space
    cyc(1, mkreg(0, 1, 10'h3FF), 1, 36'h0);
    for (int k = 0; k < 8; k++) cyc(0, 0, 1, 36'(k * 64 + 5));
    // another base near top of implemented width
    b = 64'h7FFFF;
    base_a = b * 32768;
    cyc(1, mkreg(b, 1, 10'h0), 1, 36'h0);
    for (int k = -1; k < 7; k++) cyc(0, 0, 1, 36'(base_a + k * 64));
    // reset again clears state
    rst = 1'b1;
    cyc(0, 0, 1, 36'(base_a));
    rst = 1'b0;
    cyc(0, 0, 1, 36'(base_a));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule